// File: doc/BRIEF.md
# Serial Transmitter with Holding Buffer and Level Status

This block turns bytes into asynchronous serial frames on a single output line. Words arrive through a write strobe, wait in a small holding buffer and are shifted out one frame at a time whenever the transmitter is switched on. The frame shape comes from three configuration fields: the number of data bits, the parity mode and the length of the stop time. Each bit lasts a fixed number of oversampling ticks supplied by an external baud generator.

Software or a surrounding controller watches three status levels: transmitter switched on, everything sent, and room in the buffer. There are two interrupt flags. The completion flag is sticky: a completed transmission, or a set strobe, raises it, and only a clear strobe lowers it. The room flag is a live copy of the buffer-room status and has no set or clear. A mask selects which flags drive the single interrupt line.

Top module: `serial_tx_core`

## Requirements
- R1: After a synchronous active-low reset, the line `txd` is high. `st_enabled` is 0 and `st_done` is 1. `st_room` is 1. `flags` reads 2'b10 (bit 0 is the completion flag and is clear, bit 1 is room). `irq` is 0 while `irq_mask` is 0.
- R2: The holding buffer stores two words. A write that arrives while both entries are occupied is discarded and is never sent. A write that arrives while an entry is free is kept and is sent in arrival order.
- R3: A pulse on `cmd_on` switches the transmitter on. A pulse on `cmd_off` switches it off, and off wins if both pulse in the same cycle. `st_enabled` shows the state from the next cycle. A new frame starts only while the transmitter is on. A frame already on the line when it is switched off runs to its end.
- R4: The line idles high. A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the high stop time. Every bit other than the stop time lasts 16 baud ticks. The start bit appears on `txd` in the cycle after a word is taken from the buffer.
- R5: `cfg_width` holds the data-bit count minus 3, so values 2 to 5 select 5 to 8 bits. Values below 2 select 5 bits, and values above 5 select 8 bits.
- R6: `cfg_parity` 2'b00 and 2'b01 send no parity bit. 2'b10 sends even parity, which makes the count of ones over the data and parity bits even. 2'b11 sends odd parity.
- R7: `cfg_stop` 2'b00 gives a high stop time of 8 ticks (half a bit). 2'b01 gives 16 ticks. 2'b11 and 2'b10 give 32 ticks.
- R8: With `room_any` at 0, `st_room` is 1 only when the buffer is empty. With `room_any` at 1, `st_room` is 1 whenever at least one entry is free.
- R9: `st_done` is 1 exactly when the buffer is empty and no frame is on the line. Flag bit 0 is set on the clock after `st_done` goes from 0 to 1, or on the clock after a `done_set` pulse. It is cleared on the clock after a `done_clr` pulse. Setting wins over clearing, and the flag otherwise holds its value.
- R10: Flag bit 1 always equals `st_room` and has no set or clear input.
- R11: `irq` is 1 exactly when some flag bit and the same bit of `irq_mask` are both 1.
- R12: The width, parity and stop settings are captured when a word is taken from the buffer. A change during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick, 16 per bit |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Word to send |
| cmd_on | input | 1 | Switch-on pulse |
| cmd_off | input | 1 | Switch-off pulse |
| cfg_width | input | 4 | Data-bit count minus 3 |
| cfg_parity | input | 2 | Parity mode |
| cfg_stop | input | 2 | Stop-time length code |
| room_any | input | 1 | Room status threshold select |
| done_set | input | 1 | Set pulse for the completion flag |
| done_clr | input | 1 | Clear pulse for the completion flag |
| irq_mask | input | 2 | Enable mask for flag bits 1:0 |
| txd | output | 1 | Serial output line |
| st_enabled | output | 1 | Transmitter switched on |
| st_done | output | 1 | Buffer empty and line idle |
| st_room | output | 1 | Buffer room status |
| flags | output | 2 | Bit 1 room, bit 0 completion |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check these local rules. The buffer never overflows or underflows, and a write to a full buffer leaves it unchanged. A start bit follows every load, and no frame begins while the transmitter is off. Switching off takes effect on the next cycle. The completion flag is sticky and obeys its clear pulse. The room status drops after a write when the threshold needs an empty buffer. Other behaviour is shown only by the bench, whose cycle model compares the line and every status output on each clock. That covers exact bit timing for each width, parity and stop code, the clamping of out-of-range widths, and dropped writes never reaching the line. It also covers settings captured at frame start, and a frame finishing after the transmitter is switched off.

// File: rtl/serial_tx_pkg.sv
// Shared types and field decoders for the serial transmitter.
// Assumes a maximum of 8 data bits per frame.
package serial_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    typedef enum logic [1:0] {
        PAR_NONE,
        PAR_EVEN,
        PAR_ODD
    } par_mode_e;

    // Width code is count minus 3; out-of-range codes clamp to 5 or 8 bits.
    function automatic logic [3:0] decode_width(input logic [3:0] code);
        if (code < 4'd2) begin
            return 4'd5;
        end else if (code > 4'd5) begin
            return 4'd8;
        end
        return code + 4'd3;
    endfunction

    // Upper bit enables parity, lower bit picks odd.
    function automatic par_mode_e decode_parity(input logic [1:0] code);
        case (code)
            2'b10:   return PAR_EVEN;
            2'b11:   return PAR_ODD;
            default: return PAR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/stx_hold_fifo.sv
// Holding buffer: a small circular queue of DEPTH words.
// A push while full is discarded. The consumer pops only when head_valid is high.
module stx_hold_fifo #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             accept;

    assign accept     = push_req && (level < FULL);
    assign head_valid = (level != '0);
    assign head_data  = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            level <= level + LW'(accept) - LW'(pop);
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level != '0);
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && level == FULL && !pop) |=> (level == FULL));
endmodule

// File: rtl/stx_shifter.sv
// Frame sequencer: takes one word from the buffer, latches the frame settings
// and drives start, data (LSB first), optional parity and stop time on txd.
// Assumes baud_tick is a one-cycle pulse, OVS ticks per bit, OVS even.
module stx_shifter
    import serial_tx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          enable,
    input  logic          head_valid,
    input  logic [DW-1:0] head_data,
    input  logic [3:0]    cfg_width,
    input  logic [1:0]    cfg_parity,
    input  logic [1:0]    cfg_stop,
    output logic          load,
    output logic          busy,
    output logic          txd
);
    localparam int CW = $clog2(2 * OVS + 1);
    localparam int IW = $clog2(DW + 1);
    localparam logic [CW-1:0] BIT_TICKS  = CW'(OVS);
    localparam logic [CW-1:0] STOP_HALF  = CW'(OVS / 2);
    localparam logic [CW-1:0] STOP_ONE   = CW'(OVS);
    localparam logic [CW-1:0] STOP_TWO   = CW'(2 * OVS);

    tx_phase_e     phase;
    logic [CW-1:0] tcnt;
    logic [IW-1:0] bidx;
    logic [DW-1:0] sreg;
    logic [IW-1:0] nbits;
    logic          par_on;
    logic          par_bit;
    logic [CW-1:0] stop_lim;

    logic [IW-1:0] ld_nbits;
    logic [DW-1:0] ld_mask;
    par_mode_e     ld_par;
    logic          ld_pbit;
    logic [CW-1:0] ld_stop;
    logic [CW-1:0] lim;
    logic          bit_end;

    assign busy = (phase != PH_IDLE);
    assign load = enable && !busy && head_valid;

    // Decode the frame settings that a load would capture.
    always_comb begin
        ld_nbits = IW'(decode_width(cfg_width));
        for (int i = 0; i < DW; i++) begin
            ld_mask[i] = (i < int'(ld_nbits));
        end
        ld_par  = decode_parity(cfg_parity);
        ld_pbit = (^(head_data & ld_mask)) ^ (ld_par == PAR_ODD);
        if (cfg_stop[1]) begin
            ld_stop = STOP_TWO;
        end else if (cfg_stop[0]) begin
            ld_stop = STOP_ONE;
        end else begin
            ld_stop = STOP_HALF;
        end
    end

    // Length of the current bit in ticks and end-of-bit detection.
    always_comb begin
        lim     = (phase == PH_STOP) ? stop_lim : BIT_TICKS;
        bit_end = baud_tick && (tcnt == lim - 1'b1);
    end

    // Phase sequencing, tick counting and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            sreg     <= '0;
            nbits    <= '0;
            par_on   <= 1'b0;
            par_bit  <= 1'b0;
            stop_lim <= '0;
        end else if (load) begin
            phase    <= PH_START;
            tcnt     <= '0;
            bidx     <= '0;
            sreg     <= head_data & ld_mask;
            nbits    <= ld_nbits;
            par_on   <= (ld_par != PAR_NONE);
            par_bit  <= ld_pbit;
            stop_lim <= ld_stop;
        end else if (busy && baud_tick) begin
            if (!bit_end) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                case (phase)
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        sreg <= sreg >> 1;
                        if (bidx == nbits - 1'b1) begin
                            phase <= par_on ? PH_PARITY : PH_STOP;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                    PH_PARITY: phase <= PH_STOP;
                    default:   phase <= PH_IDLE;
                endcase
            end
        end
    end

    // Line level for each phase.
    always_comb begin
        case (phase)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = sreg[0];
            PH_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

    assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !txd));
    assert_no_start_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !busy) |=> !busy);
    assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP) |-> txd);
endmodule

// File: rtl/stx_flags.sv
// Interrupt flag unit: sticky completion flag (bit 0) raised on the rising
// edge of the done level or by a set pulse, lowered by a clear pulse;
// room flag (bit 1) is a live copy of the room level. Assumes level inputs.
module stx_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_lvl,
    input  logic       room_lvl,
    input  logic       done_set,
    input  logic       done_clr,
    input  logic [1:0] irq_mask,
    output logic [1:0] flags,
    output logic       irq
);
    logic done_prev;
    logic done_flag;
    logic done_rise;

    assign done_rise = done_lvl && !done_prev;
    assign flags     = {room_lvl, done_flag};
    assign irq       = |(flags & irq_mask);

    // Remember the done level to find its rising edge; reset matches idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_prev <= 1'b1;
        end else begin
            done_prev <= done_lvl;
        end
    end

    // Sticky completion flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (done_set || done_rise) begin
            done_flag <= 1'b1;
        end else if (done_clr) begin
            done_flag <= 1'b0;
        end
    end

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !done_clr) |=> flags[0]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> flags[0]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !done_set && !(done_lvl && !done_prev)) |=> !flags[0]);
endmodule

// File: rtl/serial_tx_core.sv
// Serial transmitter top: holding buffer, frame sequencer, on/off state,
// status levels and masked interrupt flags. Assumes one baud_tick source.
module serial_tx_core #(
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 2,
    parameter int OVS       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_on,
    input  logic              cmd_off,
    input  logic [3:0]        cfg_width,
    input  logic [1:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    input  logic              room_any,
    input  logic              done_set,
    input  logic              done_clr,
    input  logic [1:0]        irq_mask,
    output logic              txd,
    output logic              st_enabled,
    output logic              st_done,
    output logic              st_room,
    output logic [1:0]        flags,
    output logic              irq
);
    localparam int LW = $clog2(BUF_DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(BUF_DEPTH);

    logic              load;
    logic              busy;
    logic              head_valid;
    logic [DATA_W-1:0] head_data;
    logic [LW-1:0]     fill;

    stx_hold_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (wr_valid),
        .push_data  (wr_data),
        .pop        (load),
        .head_valid (head_valid),
        .head_data  (head_data),
        .level      (fill)
    );

    stx_shifter #(.DW(DATA_W), .OVS(OVS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .enable     (st_enabled),
        .head_valid (head_valid),
        .head_data  (head_data),
        .cfg_width  (cfg_width),
        .cfg_parity (cfg_parity),
        .cfg_stop   (cfg_stop),
        .load       (load),
        .busy       (busy),
        .txd        (txd)
    );

    // On/off state; switch-off has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_enabled <= 1'b0;
        end else if (cmd_off) begin
            st_enabled <= 1'b0;
        end else if (cmd_on) begin
            st_enabled <= 1'b1;
        end
    end

    // Status levels derived from buffer fill and line activity.
    always_comb begin
        st_done = (fill == '0) && !busy;
        st_room = room_any ? (fill < FULL) : (fill == '0);
    end

    stx_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_lvl (st_done),
        .room_lvl (st_room),
        .done_set (done_set),
        .done_clr (done_clr),
        .irq_mask (irq_mask),
        .flags    (flags),
        .irq      (irq)
    );

    assert_off_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> !st_enabled);
    assert_done_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> txd);
    assert_room_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !room_any && st_room) |=> (!st_room || room_any));
endmodule

// File: tb/tb_serial_tx_core.sv
`timescale 1ns/100ps
module tb_serial_tx_core;
    localparam int BUF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmd_on = 1'b0;
    logic       cmd_off = 1'b0;
    logic [3:0] cfg_width = 4'd5;
    logic [1:0] cfg_parity = 2'b00;
    logic [1:0] cfg_stop = 2'b01;
    logic       room_any = 1'b1;
    logic       done_set = 1'b0;
    logic       done_clr = 1'b0;
    logic [1:0] irq_mask = 2'b00;
    logic       txd, st_enabled, st_done, st_room, irq;
    logic [1:0] flags;

    always #2.5 clk = ~clk;

    serial_tx_core dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .cfg_width(cfg_width), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .room_any(room_any), .done_set(done_set), .done_clr(done_clr),
        .irq_mask(irq_mask), .txd(txd), .st_enabled(st_enabled),
        .st_done(st_done), .st_room(st_room), .flags(flags), .irq(irq)
    );

    int    n_tests = 0;
    int    n_fail = 0;
    string scen = "R1";
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;

    // Behavioural reference model state.
    byte unsigned mq[$];
    int   m_ph;            // 0 idle, 1 start, 2 data, 3 parity, 4 stop
    int   m_tc, m_bi, m_nb, m_stop;
    bit   m_paron, m_pbit, m_en, m_dprev, m_f0;
    logic [7:0] m_sr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic void model_load(input byte unsigned d);
        int ones;
        if (cfg_width < 2) m_nb = 5;
        else if (cfg_width > 5) m_nb = 8;
        else m_nb = int'(cfg_width) + 3;
        m_sr = d & 8'((1 << m_nb) - 1);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += m_sr[i];
        m_paron = cfg_parity[1];
        m_pbit  = (ones % 2 == 1) ^ (cfg_parity == 2'b11);
        m_stop  = cfg_stop[1] ? 32 : (cfg_stop[0] ? 16 : 8);
        m_ph = 1; m_tc = 0; m_bi = 0;
    endfunction

    // Reference model advances on each rising edge with the inputs of that cycle.
    always @(posedge clk) begin
        int cnt, lim;
        bit ld, psh, dnow;
        byte unsigned d;
        if (!rst_n) begin
            mq.delete(); m_ph = 0; m_tc = 0; m_en = 0; m_dprev = 1; m_f0 = 0;
        end else begin
            cnt  = mq.size();
            ld   = m_en && (m_ph == 0) && (cnt > 0);
            psh  = wr_valid && (cnt < BUF);
            dnow = (cnt == 0) && (m_ph == 0);
            if (done_set || (dnow && !m_dprev)) m_f0 = 1;
            else if (done_clr) m_f0 = 0;
            m_dprev = dnow;
            if (ld) begin
                d = mq.pop_front();
                model_load(d);
            end else if (m_ph != 0 && baud_tick) begin
                lim = (m_ph == 4) ? m_stop : 16;
                if (m_tc != lim - 1) m_tc++;
                else begin
                    m_tc = 0;
                    case (m_ph)
                        1: m_ph = 2;
                        2: begin
                            m_sr = m_sr >> 1;
                            if (m_bi == m_nb - 1) m_ph = m_paron ? 3 : 4;
                            else m_bi++;
                        end
                        3: m_ph = 4;
                        default: m_ph = 0;
                    endcase
                end
            end
            if (psh) mq.push_back(wr_data);
            if (cmd_off) m_en = 0;
            else if (cmd_on) m_en = 1;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        logic e_txd, e_room;
        logic [1:0] e_flags;
        if (cmp_on) begin
            case (m_ph)
                1: e_txd = 1'b0;
                2: e_txd = m_sr[0];
                3: e_txd = m_pbit;
                default: e_txd = 1'b1;
            endcase
            e_room  = room_any ? (mq.size() < BUF) : (mq.size() == 0);
            e_flags = {e_room, m_f0};
            chk($sformatf("R4 %s txd", scen), txd, e_txd);
            chk("R3 st_enabled", st_enabled, m_en);
            chk("R9 st_done", st_done, (mq.size() == 0) && (m_ph == 0));
            chk("R8 st_room", st_room, e_room);
            chk("R9 flag0", flags[0], e_flags[0]);
            chk("R10 flag1", flags[1], e_flags[1]);
            chk("R11 irq", irq, |(e_flags & irq_mask));
        end
    end

    // Baud tick every fourth clock.
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            baud_tick = (k % 4 == 3);
            k++;
        end
    end

    task automatic step(); @(posedge clk); #1; endtask
    task automatic put(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d; step(); wr_valid = 1'b0;
    endtask
    task automatic turn_on();  cmd_on = 1'b1;  step(); cmd_on = 1'b0;  endtask
    task automatic turn_off(); cmd_off = 1'b1; step(); cmd_off = 1'b0; endtask
    task automatic set_frame(input logic [3:0] w, input logic [1:0] p, input logic [1:0] s);
        cfg_width = w; cfg_parity = p; cfg_stop = s;
    endtask
    task automatic wait_done();
        int k = 0;
        step();
        while (!st_done && k < 6000) begin step(); k++; end
        chk({scen, " completion reached"}, st_done, 1'b1);
        step(); step();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 txd", txd, 1'b1);
        chk("R1 st_enabled", st_enabled, 1'b0);
        chk("R1 st_done", st_done, 1'b1);
        chk("R1 st_room", st_room, 1'b1);
        chk("R1 flags", flags, 2'b10);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1; cmp_on = 1'b1;
        step();

        // R2: fill while off, third write dropped
        scen = "R2";
        set_frame(4'd5, 2'b00, 2'b01);
        put(8'hA5); put(8'h3C); put(8'hFF);
        chk("R2 buffer full", st_room, 1'b0);
        chk("R2 not done", st_done, 1'b0);
        chk("R3 stays off", txd, 1'b1);
        turn_on();
        wait_done();
        chk("R9 flag set after drain", flags[0], 1'b1);

        // R5 R6 R7 frame shapes
        scen = "R5 R6 R7 5E half";
        set_frame(4'd2, 2'b10, 2'b00); put(8'h13); wait_done();
        scen = "R5 R6 R7 7O two";
        set_frame(4'd4, 2'b11, 2'b11); put(8'h5A); wait_done();
        scen = "R5 clamp high";
        set_frame(4'hF, 2'b01, 2'b01); put(8'h81); wait_done();
        scen = "R5 clamp low";
        set_frame(4'h0, 2'b00, 2'b01); put(8'hFF); wait_done();
        scen = "R6 R7 odd code10";
        set_frame(4'd3, 2'b11, 2'b10); put(8'h0E); wait_done();

        // R12: settings change mid-frame
        scen = "R12";
        set_frame(4'd5, 2'b00, 2'b01); put(8'h55);
        repeat (40) step();
        set_frame(4'd2, 2'b11, 2'b11); put(8'hC3);
        wait_done();

        // R3: off mid-frame finishes the frame and holds the next one
        scen = "R3";
        set_frame(4'd5, 2'b10, 2'b01);
        put(8'h11); put(8'h22);
        repeat (30) step();
        turn_off();
        chk("R3 off status", st_enabled, 1'b0);
        repeat (1200) step();
        chk("R3 held word", st_done, 1'b0);
        chk("R3 line idle", txd, 1'b1);
        cmd_on = 1'b1; cmd_off = 1'b1; step(); cmd_on = 1'b0; cmd_off = 1'b0;
        chk("R3 off wins", st_enabled, 1'b0);
        turn_on();
        chk("R3 on status", st_enabled, 1'b1);
        wait_done();

        // R8 R10 R11: room threshold and room flag
        scen = "R8";
        turn_off();
        room_any = 1'b0; step();
        chk("R8 empty room", st_room, 1'b1);
        irq_mask = 2'b10; step();
        chk("R11 room irq", irq, 1'b1);
        put(8'h77);
        chk("R8 one word thr0", st_room, 1'b0);
        chk("R10 flag1 follows", flags[1], 1'b0);
        chk("R11 masked irq low", irq, 1'b0);
        room_any = 1'b1; step();
        chk("R8 one word thr1", st_room, 1'b1);
        chk("R10 flag1 follows thr1", flags[1], 1'b1);
        turn_on();
        wait_done();

        // R9 R11: completion flag set/clear
        scen = "R9";
        irq_mask = 2'b01; step();
        chk("R11 done irq", irq, 1'b1);
        done_clr = 1'b1; step(); done_clr = 1'b0;
        chk("R9 cleared", flags[0], 1'b0);
        chk("R11 irq low", irq, 1'b0);
        step();
        chk("R9 stays clear", flags[0], 1'b0);
        done_set = 1'b1; step(); done_set = 1'b0;
        chk("R9 set pulse", flags[0], 1'b1);
        done_clr = 1'b1; step();
        done_set = 1'b1; step(); done_set = 1'b0; done_clr = 1'b0;
        chk("R9 set wins", flags[0], 1'b1);
        irq_mask = 2'b00; step();
        chk("R11 masked off", irq, 1'b0);

        repeat (5) step();
        summary();
    end
endmodule